// File: doc/BRIEF.md
# NAND Geometry Probe Sequencer

This block runs once per start pulse, usually right after reset, to work out the page size and erase-block size of an attached raw NAND flash device. It talks to a byte-level command port and a byte-level read port. It sends an identify command and reads back the maker code and the part code. If that pair appears in a built-in list of known small-block parts, the block reports a fixed small-block geometry and stops there.

If the pair is not in the list, the block sends the identify command a second time and reads four bytes. It decodes two 2-bit fields of the last of those bytes into the page size and the block size. The maker and part codes play no part in this second decision.

The result is presented with a one-cycle done strobe. It stays on the outputs until a later run finishes. A programmable timeout ends a run if a data byte does not arrive, and that run reports an error.

Top module: `nand_geom_probe`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `done`, `busy`, `err`, `cmd_valid`, `rd_req` and `small_blk` are 0, and `page_bytes` and `blk_kbytes` are 0.
- R2: A start pulse sends command byte 0x90 and then address byte 0x00 on the command port. The block then reads exactly two bytes: first the maker code, then the part code. A read byte is taken in any cycle where `rd_req` and `rd_valid` are both high.
- R3: A (maker, part) pair in the small-block list gives `small_blk`=1, `page_bytes`=512 and `blk_kbytes`=16, and the run ends with no second identify command. The list is:
  - maker 0xEC: 33 35 36 39 43 45 46 49 53 55 56 59 71 72 73 74 75 76 78 79 E6
  - maker 0x98: 46 72 73 75 79 E6
  - maker 0xAD: 35 36 45 46 49 53 55 56 73 75 76
  - maker 0x20: 35 36 39 45 46 49 55 56 59 73 75 76 79
- R4: A pair that is not in the list leads to a second 0x90, 0x00 sequence followed by exactly four reads, with `small_blk`=0.
- R5: In the large-block case, `page_bytes` = 1024 << (fourth byte bits 1:0), which gives 1, 2, 4 or 8 KB.
- R6: In the large-block case, `blk_kbytes` = 64 << (fourth byte bits 5:4), which gives 64 to 512 KB.
- R7: Bits 7:6 and 3:2 of the fourth byte have no effect. For example, 0x15 and 0x55 give the same geometry.
- R8: The maker and part codes have no effect on large-block geometry. A part code from the list paired with a maker outside the list is treated as large-block.
- R9: `done` is high for exactly one cycle per run. `page_bytes`, `blk_kbytes` and `small_blk` change only in the cycle where `done` is high.
- R10: A start pulse while `busy` is high is ignored. The run in progress completes with a single done strobe and its normal command count.
- R11: If `rd_req` stays high without `rd_valid` for more than `timeout_lim` consecutive cycles, the run ends. `done` and `err` go high, and the geometry outputs and `small_blk` become 0.
- R12: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and `cmd_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a probe |
| timeout_lim | input | TO_W | Maximum number of wait cycles allowed per data byte |
| cmd_valid | output | 1 | Command byte offered |
| cmd_byte | output | 8 | Command or address byte |
| cmd_ready | input | 1 | Command port accepts the byte |
| rd_req | output | 1 | Sequencer wants a data byte |
| rd_valid | input | 1 | Data byte present on rd_data |
| rd_data | input | 8 | Data byte from the device |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle end-of-probe strobe |
| err | output | 1 | Last probe timed out |
| small_blk | output | 1 | Device classified as small-block |
| page_bytes | output | PG_W | Page size in bytes |
| blk_kbytes | output | BK_W | Erase block size in KB |

## Verification
The bench pushes maker and part pairs that lie near the list: a listed part code under the wrong maker, and a known maker with an unlisted part. A design that matched the part code alone would report small-block geometry for these, and a design that ignored the maker-specific lists would skip the second pass. Fourth bytes with the ignored bits set show whether a decoder reads the wrong field, because 0x15 and 0x55 would then decode differently. Runs with a stalling command port, a repeated start pulse and a silent device show, respectively, a design that drops or repeats command bytes, one that restarts mid-run, and one that hangs instead of timing out.

// File: rtl/nand_geom_pkg.sv
package nand_geom_pkg;

  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ID_ADDR = 8'h00;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_ADR,
    S_RD,
    S_CHK,
    S_FIN
  } probe_state_t;

  // Known small-block parts, grouped by maker code.
  function automatic logic small_part(input logic [7:0] mk, input logic [7:0] pt);
    logic r;
    r = 1'b0;
    case (mk)
      8'hEC: case (pt)
        8'h33, 8'h35, 8'h36, 8'h39, 8'h43, 8'h45, 8'h46, 8'h49,
        8'h53, 8'h55, 8'h56, 8'h59, 8'h71, 8'h72, 8'h73, 8'h74,
        8'h75, 8'h76, 8'h78, 8'h79, 8'hE6: r = 1'b1;
        default: r = 1'b0;
      endcase
      8'h98: case (pt)
        8'h46, 8'h72, 8'h73, 8'h75, 8'h79, 8'hE6: r = 1'b1;
        default: r = 1'b0;
      endcase
      8'hAD: case (pt)
        8'h35, 8'h36, 8'h45, 8'h46, 8'h49, 8'h53, 8'h55, 8'h56,
        8'h73, 8'h75, 8'h76: r = 1'b1;
        default: r = 1'b0;
      endcase
      8'h20: case (pt)
        8'h35, 8'h36, 8'h39, 8'h45, 8'h46, 8'h49, 8'h55, 8'h56,
        8'h59, 8'h73, 8'h75, 8'h76, 8'h79: r = 1'b1;
        default: r = 1'b0;
      endcase
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ngp_small_table.sv
module ngp_small_table
  import nand_geom_pkg::*;
(
  input  logic [7:0] maker,
  input  logic [7:0] part,
  output logic       hit
);
  always_comb hit = small_part(maker, part);
endmodule

// File: rtl/ngp_geom_decode.sv
module ngp_geom_decode #(
  parameter int PG_W    = 16,
  parameter int BK_W    = 10,
  parameter int PG_BASE = 1024,
  parameter int BK_BASE = 64
) (
  input  logic [1:0]      pg_code,
  input  logic [1:0]      bk_code,
  output logic [PG_W-1:0] pg_size,
  output logic [BK_W-1:0] bk_size
);
  always_comb begin
    pg_size = PG_W'(PG_BASE) << pg_code;
    bk_size = BK_W'(BK_BASE) << bk_code;
  end
endmodule

// File: rtl/ngp_wait_timer.sv
module ngp_wait_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            waiting,
  input  logic [TO_W-1:0] lim,
  output logic            expired
);
  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !waiting) cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end

  always_comb expired = waiting && (cnt >= lim);
endmodule

// File: rtl/nand_geom_probe.sv
module nand_geom_probe
  import nand_geom_pkg::*;
#(
  parameter int TO_W     = 16,
  parameter int PG_W     = 16,
  parameter int BK_W     = 10,
  parameter int SMALL_PG = 512,
  parameter int SMALL_BK = 16,
  parameter int PG_BASE  = 1024,
  parameter int BK_BASE  = 64,
  parameter int ID1_N    = 2,
  parameter int ID2_N    = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [TO_W-1:0] timeout_lim,
  output logic            cmd_valid,
  output logic [7:0]      cmd_byte,
  input  logic            cmd_ready,
  output logic            rd_req,
  input  logic            rd_valid,
  input  logic [7:0]      rd_data,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            small_blk,
  output logic [PG_W-1:0] page_bytes,
  output logic [BK_W-1:0] blk_kbytes
);
  localparam int CNT_W    = $clog2(ID2_N);
  localparam int GEOM_IDX = ID2_N - 1;

  probe_state_t     state;
  logic             pass2;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       maker_q, part_q;
  logic [1:0]       pg_code_q, bk_code_q;
  logic             tbl_hit, tmo;
  logic [PG_W-1:0]  dec_pg;
  logic [BK_W-1:0]  dec_bk;

  ngp_small_table tbl_i (
    .maker (maker_q),
    .part  (part_q),
    .hit   (tbl_hit)
  );

  ngp_geom_decode #(
    .PG_W(PG_W), .BK_W(BK_W), .PG_BASE(PG_BASE), .BK_BASE(BK_BASE)
  ) dec_i (
    .pg_code (pg_code_q),
    .bk_code (bk_code_q),
    .pg_size (dec_pg),
    .bk_size (dec_bk)
  );

  ngp_wait_timer #(.TO_W(TO_W)) tmr_i (
    .clk     (clk),
    .rst     (rst),
    .waiting (rd_req && !rd_valid),
    .lim     (timeout_lim),
    .expired (tmo)
  );

  always_comb busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      pass2      <= 1'b0;
      cnt        <= '0;
      cmd_valid  <= 1'b0;
      cmd_byte   <= '0;
      rd_req     <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      small_blk  <= 1'b0;
      page_bytes <= '0;
      blk_kbytes <= '0;
      maker_q    <= '0;
      part_q     <= '0;
      pg_code_q  <= '0;
      bk_code_q  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          state     <= S_CMD;
          pass2     <= 1'b0;
          err       <= 1'b0;
          cmd_valid <= 1'b1;
          cmd_byte  <= OP_IDENT;
        end
        S_CMD: if (cmd_ready) begin
          cmd_byte <= OP_ID_ADDR;
          state    <= S_ADR;
        end
        S_ADR: if (cmd_ready) begin
          cmd_valid <= 1'b0;
          rd_req    <= 1'b1;
          cnt       <= '0;
          state     <= S_RD;
        end
        S_RD: begin
          if (tmo) begin
            rd_req     <= 1'b0;
            err        <= 1'b1;
            done       <= 1'b1;
            small_blk  <= 1'b0;
            page_bytes <= '0;
            blk_kbytes <= '0;
            state      <= S_IDLE;
          end else if (rd_valid) begin
            cnt <= cnt + 1'b1;
            if (!pass2 && cnt == CNT_W'(0)) maker_q <= rd_data;
            if (!pass2 && cnt == CNT_W'(1)) part_q  <= rd_data;
            if (pass2 && cnt == CNT_W'(GEOM_IDX)) begin
              pg_code_q <= rd_data[1:0];
              bk_code_q <= rd_data[5:4];
            end
            if (!pass2 && cnt == CNT_W'(ID1_N - 1)) begin
              rd_req <= 1'b0;
              state  <= S_CHK;
            end else if (pass2 && cnt == CNT_W'(ID2_N - 1)) begin
              rd_req <= 1'b0;
              state  <= S_FIN;
            end
          end
        end
        S_CHK: begin
          if (tbl_hit) begin
            small_blk  <= 1'b1;
            page_bytes <= PG_W'(SMALL_PG);
            blk_kbytes <= BK_W'(SMALL_BK);
            done       <= 1'b1;
            state      <= S_IDLE;
          end else begin
            pass2     <= 1'b1;
            cmd_valid <= 1'b1;
            cmd_byte  <= OP_IDENT;
            state     <= S_CMD;
          end
        end
        S_FIN: begin
          small_blk  <= 1'b0;
          page_bytes <= dec_pg;
          blk_kbytes <= dec_bk;
          done       <= 1'b1;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_geom_probe_chk.sv
module nand_geom_probe_chk #(
  parameter int PG_W     = 16,
  parameter int BK_W     = 10,
  parameter int SMALL_PG = 512,
  parameter int SMALL_BK = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            cmd_valid,
  input logic [7:0]      cmd_byte,
  input logic            cmd_ready,
  input logic            rd_req,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            small_blk,
  input logic [PG_W-1:0] page_bytes,
  input logic [BK_W-1:0] blk_kbytes
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid && !rd_req);

  p_port_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && rd_req));

  p_small_geom_r3: assert property (@(posedge clk) disable iff (rst)
    done && small_blk |-> page_bytes == PG_W'(SMALL_PG) && blk_kbytes == BK_W'(SMALL_BK));

  p_page_pow2_r5: assert property (@(posedge clk) disable iff (rst)
    done && !err |-> $countones(page_bytes) == 1 && $countones(blk_kbytes) == 1);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_geom_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |=> done || ($stable(page_bytes) && $stable(blk_kbytes) && $stable(small_blk)));

  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    busy && start && !done |=> busy || done);

  p_err_clear_r11: assert property (@(posedge clk) disable iff (rst)
    done && err |-> page_bytes == '0 && blk_kbytes == '0 && !small_blk);

  p_cmd_hold_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte));
endmodule

bind nand_geom_probe nand_geom_probe_chk #(
  .PG_W(PG_W), .BK_W(BK_W), .SMALL_PG(SMALL_PG), .SMALL_BK(SMALL_BK)
) chk_i (
  .clk(clk), .rst(rst), .start(start), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .cmd_ready(cmd_ready), .rd_req(rd_req), .busy(busy), .done(done), .err(err),
  .small_blk(small_blk), .page_bytes(page_bytes), .blk_kbytes(blk_kbytes)
);

// File: tb/nand_geom_probe_tb_top.sv
module nand_geom_probe_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] timeout_lim = 16'd64;
  logic        cmd_valid, cmd_ready;
  logic [7:0]  cmd_byte;
  logic        rd_req, rd_valid;
  logic [7:0]  rd_data;
  logic        busy, done, err, small_blk;
  logic [15:0] page_bytes;
  logic [9:0]  blk_kbytes;

  always #10 clk = ~clk;

  nand_geom_probe dut_i (
    .clk(clk), .rst(rst), .start(start), .timeout_lim(timeout_lim),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err), .small_blk(small_blk),
    .page_bytes(page_bytes), .blk_kbytes(blk_kbytes)
  );

  int tests = 0;
  int fails = 0;

  // device model state
  logic [7:0] idb [4];
  logic [7:0] cmd_log [8];
  int cmd_n = 0, rd_n = 0, done_n = 0, idx = 0, wcnt = 0, lat = 0;
  bit mute = 1'b0, stall_cmd = 1'b0;

  // {maker, part, byte4, small, page, blk}
  localparam logic [50:0] VEC [11] = '{
    {8'hEC, 8'h76, 8'h00, 1'b1, 16'd512,  10'd16},
    {8'h98, 8'hE6, 8'h00, 1'b1, 16'd512,  10'd16},
    {8'hAD, 8'h35, 8'h00, 1'b1, 16'd512,  10'd16},
    {8'h20, 8'h79, 8'h00, 1'b1, 16'd512,  10'd16},
    {8'hEC, 8'hD3, 8'h15, 1'b0, 16'd2048, 10'd128},
    {8'hEC, 8'hD3, 8'h55, 1'b0, 16'd2048, 10'd128},
    {8'h98, 8'hD1, 8'h00, 1'b0, 16'd1024, 10'd64},
    {8'h2C, 8'hDA, 8'h3A, 1'b0, 16'd4096, 10'd512},
    {8'h12, 8'h46, 8'h23, 1'b0, 16'd8192, 10'd256},
    {8'h98, 8'h76, 8'hC4, 1'b0, 16'd1024, 10'd64},
    {8'hAD, 8'h79, 8'h11, 1'b0, 16'd2048, 10'd128}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder: command monitor and data source, acting at falling edges
  initial begin
    cmd_ready = 1'b1; rd_valid = 1'b0; rd_data = '0;
    forever begin
      @(negedge clk);
      cmd_ready = stall_cmd ? ~cmd_ready : 1'b1;
      if (cmd_valid && cmd_ready) begin
        if (cmd_n < 8) cmd_log[cmd_n] = cmd_byte;
        cmd_n++;
        if (cmd_byte == 8'h90) idx = 0;
      end
      if (done) done_n++;
      if (rd_valid) begin
        rd_n++; idx++; rd_valid = 1'b0; wcnt = 0;
      end else if (rd_req && !mute) begin
        if (wcnt >= lat) begin
          rd_valid = 1'b1;
          rd_data  = idb[idx % 4];
        end else wcnt++;
      end
    end
  end

  task automatic run_probe(input logic [7:0] mk, pt, b4, input int restart_at, output int cyc);
    bit seen;
    idb[0] = mk; idb[1] = pt; idb[2] = 8'hA5; idb[3] = b4;
    cmd_n = 0; rd_n = 0; done_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 1'b0; cyc = 1;
    while (!seen && cyc < 3000) begin
      if (cyc == restart_at) start = 1'b1;
      else start = 1'b0;
      if (done) seen = 1'b1;
      else begin @(negedge clk); cyc++; end
    end
    start = 1'b0;
    chk("R2 done reached", {31'd0, seen}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] pg_hold;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 cmd_valid", {31'd0, cmd_valid}, 0);
    chk("R1 rd_req", {31'd0, rd_req}, 0);
    chk("R1 err/small", {30'd0, err, small_blk}, 0);
    chk("R1 geometry", {6'd0, page_bytes, blk_kbytes}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {28'd0, busy, done, cmd_valid, rd_req}, 0);

    // vector walk: R2 R3 R4 R5 R6 R7 R8
    foreach (VEC[i]) begin
      logic [50:0] v;
      v = VEC[i];
      run_probe(v[50:43], v[42:35], v[34:27], -1, cyc);
      chk("R3/R4 small_blk", {31'd0, small_blk}, {31'd0, v[26]});
      chk("R5 page_bytes", {16'd0, page_bytes}, {16'd0, v[25:10]});
      chk("R6 blk_kbytes", {22'd0, blk_kbytes}, {22'd0, v[9:0]});
      chk("R11 err clear", {31'd0, err}, 0);
      chk("R2 first cmd", {24'd0, cmd_log[0]}, 32'h90);
      chk("R2 first addr", {24'd0, cmd_log[1]}, 32'h00);
      @(negedge clk);
      chk("R3/R4 cmd count", cmd_n, v[26] ? 2 : 4);
      chk("R3/R4 read count", rd_n, v[26] ? 2 : 6);
      if (!v[26]) begin
        chk("R4 second cmd", {24'd0, cmd_log[2]}, 32'h90);
        chk("R4 second addr", {24'd0, cmd_log[3]}, 32'h00);
      end
      chk("R9 done one cycle", {31'd0, done}, 0);
    end

    // R7 direct comparison of ignored bits
    run_probe(8'h01, 8'h02, 8'hCE, -1, cyc);
    chk("R7 0xCE page", {16'd0, page_bytes}, 32'd4096);
    chk("R7 0xCE block", {22'd0, blk_kbytes}, 32'd64);

    // R9 hold after done
    pg_hold = page_bytes;
    repeat (10) @(negedge clk);
    chk("R9 hold page", {16'd0, page_bytes}, {16'd0, pg_hold});
    chk("R9 hold block", {22'd0, blk_kbytes}, 32'd64);
    chk("R9 single done", done_n, 1);

    // R10 restart while busy
    run_probe(8'h55, 8'h66, 8'h21, 4, cyc);
    @(negedge clk);
    chk("R10 cmd count", cmd_n, 4);
    chk("R10 done count", done_n, 1);
    chk("R10 page", {16'd0, page_bytes}, 32'd2048);
    chk("R10 block", {22'd0, blk_kbytes}, 32'd256);

    // R12 stalled command port with slow data, still within the limit
    stall_cmd = 1'b1; lat = 5; timeout_lim = 16'd20;
    run_probe(8'h77, 8'h88, 8'h33, -1, cyc);
    @(negedge clk);
    chk("R12 cmd count", cmd_n, 4);
    chk("R12 bytes in order", {cmd_log[0], cmd_log[1], cmd_log[2], cmd_log[3]}, 32'h90009000);
    chk("R11 no early timeout", {31'd0, err}, 0);
    chk("R12 page", {16'd0, page_bytes}, 32'd8192);
    stall_cmd = 1'b0; lat = 0;

    // R11 timeout on a silent device
    mute = 1'b1;
    run_probe(8'hEC, 8'h76, 8'h00, -1, cyc);
    chk("R11 err", {31'd0, err}, 1);
    chk("R11 geometry zero", {6'd0, page_bytes, blk_kbytes}, 0);
    chk("R11 small zero", {31'd0, small_blk}, 0);
    chk("R11 waited past limit", {31'd0, cyc > 20}, 1);
    @(negedge clk);
    chk("R11 back to idle", {30'd0, busy, rd_req}, 0);
    mute = 1'b0;

    // recovery after error
    run_probe(8'h98, 8'h72, 8'h00, -1, cyc);
    chk("R11 err cleared on new run", {31'd0, err}, 0);
    chk("R3 small after recovery", {31'd0, small_blk}, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule